// File: doc/BRIEF.md
# Line-Address Outstanding Request Tracker

This block sits beside a first-level cache controller and keeps track of memory requests that have been issued but not yet completed. It holds two small associative tables, one for read-class requests and one for write-class requests. Every entry is keyed by the cache-line address of its request. For each new request the tracker decides whether the request may go ahead (it is entered in a table), whether it collides with work already in flight on the same line, or whether its table has no room. When the controller reports that a request has finished, the matching entry is released.

A locked read-modify-write sequence can reserve a line. After the locked read completes, only the matching locked write may use that line until that write completes. An age watchdog scans the tables at intervals that software can set, and it raises a sticky deadlock flag when any entry has waited too long. Four saturating counters record how often each kind of collision happened.

There is no back-pressure at either edge. A request or a completion can be presented in any cycle, and each is taken in the cycle its valid is high. The verdict for a request appears on `rsp_valid`/`rsp_code` one cycle later. A caller that receives "aliased" or "full" simply retries later.

Top module: `lart_tracker`

## Requirements
- R1: Matching ignores the low `log2(LINE_BYTES)` address bits (bits [5:0] for 64-byte lines). Two addresses in the same line are treated as the same line, and addresses in different lines never match.
- R2: Request kinds are encoded on `req_kind` as 0 load, 1 instruction fetch, 2 store, 3 RMW read, 4 RMW write, 5 load-linked, 6 store-conditional, 7 locked RMW read, 8 locked RMW write, 9 flush. Kinds 0 and 1 are read-class and every other value is write-class. A write-class request is aliased if the read table holds its line, and this bumps `ev_st_ld`. Otherwise it is aliased if the write table holds its line, and this bumps `ev_st_st`.
- R3: A read-class request is aliased if the write table holds its line, and this bumps `ev_ld_st`. Otherwise it is aliased if the read table holds its line, and this bumps `ev_ld_ld`.
- R4: While a line is locked, any request to that line other than kind 8 is aliased and bumps no counter. Requests to other lines are not affected.
- R5: When a write-table entry of kind 7 completes, its line becomes locked. When an entry of kind 8 completes on the locked line, the lock is released.
- R6: An issued request adds one to `out_count` and a completion that hits subtracts one. `out_count` always equals the number of occupied entries in both tables.
- R7: If a request is neither blocked nor aliased and its table has all `ENTRIES` slots in use, it is answered full. The order of precedence is lock block, then alias, then full.
- R8: `rsp_code` is 0 for issued, 1 for aliased and 2 for full. It is valid with `rsp_valid` in the cycle after the request. A request sees the tables and the lock as they stood before a completion presented in the same cycle.
- R9: A completion whose line is absent from the table selected by `cpl_is_write` sets the sticky `cpl_error` flag.
- R10: An accepted insert arms the watchdog if it is idle, loading `dl_limit`. `dl_limit` cycles later the watchdog scans every entry, and an entry whose age is `dl_limit` or more sets `deadlock`. After a scan the watchdog re-arms if entries remain and goes idle otherwise. `dl_limit` must be at least 1.
- R11: `deadlock` and `cpl_error` stay set until reset.
- R12: Each event counter saturates at `2^CNT_W-1`.
- R13: Reset empties both tables, clears the lock, the flags, the counters and `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_kind | input | 4 | Request kind (encoding in R2) |
| rsp_valid | output | 1 | Verdict for the previous cycle's request |
| rsp_code | output | 2 | 0 issued, 1 aliased, 2 full |
| cpl_valid | input | 1 | A completion is presented this cycle |
| cpl_is_write | input | 1 | Completion targets the write table |
| cpl_addr | input | ADDR_W | Address of the completing request |
| dl_limit | input | AGE_W-1 | Watchdog age threshold and scan interval, in cycles |
| out_count | output | clog2(2*ENTRIES+1) | Number of in-flight requests |
| deadlock | output | 1 | Sticky: an entry reached the age threshold |
| cpl_error | output | 1 | Sticky: a completion matched no entry |
| ev_st_ld | output | CNT_W | Write-class aliased on a pending read |
| ev_st_st | output | CNT_W | Write-class aliased on a pending write |
| ev_ld_ld | output | CNT_W | Read-class aliased on a pending read |
| ev_ld_st | output | CNT_W | Read-class aliased on a pending write |

## Verification
The bench aims at the following corner cases:
- Two addresses that share a line but differ in offset. A design that compared full addresses would issue the second one twice.
- A request to a line whose completion arrives in the same cycle. A design that looked past the completion would issue where the aliased verdict is expected.
- A full table on a line that also aliases. Getting the precedence wrong returns full instead of aliased.
- A locked line visited by loads, ordinary stores and the locked write. A lock that leaked would either let a load through or hold back the locked write.
- Saturation of a counter that is pushed well past its limit.
- An entry that is young at the first watchdog scan but old at the second. A watchdog that did not re-arm, or that measured age from its own arming, would miss it.

// File: rtl/lart_pkg.sv
package lart_pkg;

  localparam logic [3:0] K_LOAD    = 4'd0;
  localparam logic [3:0] K_IFETCH  = 4'd1;
  localparam logic [3:0] K_LOCK_RD = 4'd7;
  localparam logic [3:0] K_LOCK_WR = 4'd8;

  typedef enum logic [1:0] {
    ST_ISSUED  = 2'd0,
    ST_ALIASED = 2'd1,
    ST_FULL    = 2'd2
  } status_e;

  // event counter slots
  localparam int EV_ST_LD = 0;
  localparam int EV_ST_ST = 1;
  localparam int EV_LD_LD = 2;
  localparam int EV_LD_ST = 3;
  localparam int EV_NUM   = 4;

  function automatic logic is_read_kind(input logic [3:0] k);
    return (k == K_LOAD) || (k == K_IFETCH);
  endfunction

endpackage

// File: rtl/lart_table.sv
module lart_table #(
  parameter int ENTRIES = 8,
  parameter int LN_W    = 26,
  parameter int AGE_W   = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int OCC_W  = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LN_W-1:0]  look_line,
  output logic             look_hit,
  output logic             full,
  input  logic             ins_en,
  input  logic [3:0]       ins_kind,
  input  logic [AGE_W-1:0] now,
  input  logic             rem_en,
  input  logic [LN_W-1:0]  rem_line,
  output logic             rem_hit,
  output logic [3:0]       rem_kind,
  input  logic [AGE_W-2:0] limit,
  output logic             aged,
  output logic [OCC_W-1:0] occ
);

  logic             v_q    [ENTRIES];
  logic [LN_W-1:0]  line_q [ENTRIES];
  logic [AGE_W-1:0] iss_q  [ENTRIES];
  logic [3:0]       kind_q [ENTRIES];

  logic [ENTRIES-1:0] look_match, rem_match, ins_sel, old_vec;
  logic [IDX_W-1:0]   free_idx;
  logic               any_free;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign look_match[g] = v_q[g] && (line_q[g] == look_line);
    assign rem_match[g]  = v_q[g] && (line_q[g] == rem_line);
    assign old_vec[g]    = v_q[g] && ((now - iss_q[g]) >= {1'b0, limit});
    assign ins_sel[g]    = ins_en && any_free && (free_idx == IDX_W'(g));
  end

  assign look_hit = |look_match;
  assign rem_hit  = |rem_match;
  assign aged     = |old_vec;
  assign full     = !any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!v_q[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  always_comb begin
    rem_kind = '0;
    occ      = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      rem_kind = rem_kind | (rem_match[i] ? kind_q[i] : 4'd0);
      occ      = occ + OCC_W'(v_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) v_q[i] <= 1'b0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ins_sel[i])                 v_q[i] <= 1'b1;
        else if (rem_en && rem_match[i]) v_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (ins_sel[i]) begin
        line_q[i] <= look_line;
        iss_q[i]  <= now;
        kind_q[i] <= ins_kind;
      end
    end
  end

  // R6: a line is held by at most one entry of a table
  a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_match));

  // R7: the parent never inserts into a table with no free slot
  a_r7_insert_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> !full);

endmodule

// File: rtl/lart_lock.sv
module lart_lock #(
  parameter int LN_W = 26
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic            clr_en,
  input  logic [LN_W-1:0] upd_line,
  input  logic [LN_W-1:0] chk_line,
  input  logic            chk_is_lock_wr,
  output logic            blocked
);

  logic            held_q;
  logic [LN_W-1:0] held_line_q;

  assign blocked = held_q && (held_line_q == chk_line) && !chk_is_lock_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q      <= 1'b0;
      held_line_q <= '0;
    end else if (set_en) begin
      held_q      <= 1'b1;
      held_line_q <= upd_line;
    end else if (clr_en && held_q && (held_line_q == upd_line)) begin
      held_q <= 1'b0;
    end
  end

endmodule

// File: rtl/lart_watchdog.sv
module lart_watchdog #(
  parameter int LIM_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LIM_W-1:0] limit,
  input  logic             arm,
  input  logic             busy_now,
  input  logic             busy_next,
  input  logic             aged,
  output logic             flag
);

  logic             on_q;
  logic [LIM_W-1:0] left_q;
  logic             scan;

  assign scan = on_q && (left_q == LIM_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      left_q <= '0;
      flag   <= 1'b0;
    end else begin
      if (scan) begin
        on_q   <= busy_next;
        left_q <= limit;
      end else if (on_q) begin
        left_q <= left_q - LIM_W'(1);
      end else if (arm) begin
        on_q   <= 1'b1;
        left_q <= limit;
      end
      if (scan && aged) flag <= 1'b1;
    end
  end

  // R10: the timer is running whenever anything is in flight
  a_r10_armed_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_now |-> on_q);

endmodule

// File: rtl/lart_satcnt.sv
module lart_satcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] val
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    val <= '0;
    else if (inc && (val != '1))   val <= val + W'(1);
  end

endmodule

// File: rtl/lart_tracker.sv
module lart_tracker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int ENTRIES    = 8,
  parameter int AGE_W      = 16,
  parameter int CNT_W      = 8,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LN_W      = ADDR_W - OFF_W,
  localparam int OCC_W     = $clog2(ENTRIES + 1),
  localparam int CNT_OW    = $clog2(2 * ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_kind,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  input  logic              cpl_valid,
  input  logic              cpl_is_write,
  input  logic [ADDR_W-1:0] cpl_addr,
  input  logic [AGE_W-2:0]  dl_limit,
  output logic [CNT_OW-1:0] out_count,
  output logic              deadlock,
  output logic              cpl_error,
  output logic [CNT_W-1:0]  ev_st_ld,
  output logic [CNT_W-1:0]  ev_st_st,
  output logic [CNT_W-1:0]  ev_ld_ld,
  output logic [CNT_W-1:0]  ev_ld_st
);
  import lart_pkg::*;

  logic [LN_W-1:0]  req_line, cpl_line;
  logic [AGE_W-1:0] now_q;
  logic             unused_low;

  assign req_line   = req_addr[ADDR_W-1:OFF_W];
  assign cpl_line   = cpl_addr[ADDR_W-1:OFF_W];
  assign unused_low = ^{req_addr[OFF_W-1:0], cpl_addr[OFF_W-1:0]};

  // table wiring
  logic             rd_hit, wr_hit, rd_full, wr_full;
  logic             rd_ins, wr_ins, rd_rem, wr_rem;
  logic             rd_rem_hit, wr_rem_hit;
  logic [3:0]       wr_rem_kind, rd_rem_kind_unused;
  logic             rd_aged, wr_aged;
  logic [OCC_W-1:0] rd_occ, wr_occ;

  assign rd_rem = cpl_valid && !cpl_is_write;
  assign wr_rem = cpl_valid &&  cpl_is_write;

  lart_table #(.ENTRIES(ENTRIES), .LN_W(LN_W), .AGE_W(AGE_W)) u_rd_tab (
    .clk(clk), .rst_n(rst_n), .look_line(req_line), .look_hit(rd_hit),
    .full(rd_full), .ins_en(rd_ins), .ins_kind(req_kind), .now(now_q),
    .rem_en(rd_rem), .rem_line(cpl_line), .rem_hit(rd_rem_hit),
    .rem_kind(rd_rem_kind_unused), .limit(dl_limit), .aged(rd_aged), .occ(rd_occ));

  lart_table #(.ENTRIES(ENTRIES), .LN_W(LN_W), .AGE_W(AGE_W)) u_wr_tab (
    .clk(clk), .rst_n(rst_n), .look_line(req_line), .look_hit(wr_hit),
    .full(wr_full), .ins_en(wr_ins), .ins_kind(req_kind), .now(now_q),
    .rem_en(wr_rem), .rem_line(cpl_line), .rem_hit(wr_rem_hit),
    .rem_kind(wr_rem_kind), .limit(dl_limit), .aged(wr_aged), .occ(wr_occ));

  // line lock for locked read-modify-write sequences
  logic blocked, lock_set, lock_clr;
  assign lock_set = wr_rem && wr_rem_hit && (wr_rem_kind == K_LOCK_RD);
  assign lock_clr = wr_rem && wr_rem_hit && (wr_rem_kind == K_LOCK_WR);

  lart_lock #(.LN_W(LN_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .set_en(lock_set), .clr_en(lock_clr),
    .upd_line(cpl_line), .chk_line(req_line),
    .chk_is_lock_wr(req_kind == K_LOCK_WR), .blocked(blocked));

  // request verdict
  status_e          verdict;
  logic [EV_NUM-1:0] ev_inc;
  logic             is_rd;

  assign is_rd = is_read_kind(req_kind);

  always_comb begin
    verdict = ST_ISSUED;
    ev_inc  = '0;
    rd_ins  = 1'b0;
    wr_ins  = 1'b0;
    if (req_valid) begin
      if (blocked) begin
        verdict = ST_ALIASED;
      end else if (is_rd) begin
        if (wr_hit)       begin verdict = ST_ALIASED; ev_inc[EV_LD_ST] = 1'b1; end
        else if (rd_hit)  begin verdict = ST_ALIASED; ev_inc[EV_LD_LD] = 1'b1; end
        else if (rd_full) verdict = ST_FULL;
        else              rd_ins = 1'b1;
      end else begin
        if (rd_hit)       begin verdict = ST_ALIASED; ev_inc[EV_ST_LD] = 1'b1; end
        else if (wr_hit)  begin verdict = ST_ALIASED; ev_inc[EV_ST_ST] = 1'b1; end
        else if (wr_full) verdict = ST_FULL;
        else              wr_ins = 1'b1;
      end
    end
  end

  // outstanding count
  logic              rem_any, ins_any;
  logic [CNT_OW-1:0] cnt_q, cnt_nxt;

  assign rem_any   = (rd_rem && rd_rem_hit) || (wr_rem && wr_rem_hit);
  assign ins_any   = rd_ins || wr_ins;
  assign cnt_nxt   = cnt_q + CNT_OW'(ins_any) - CNT_OW'(rem_any);
  assign out_count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      now_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_code  <= ST_ISSUED;
      cpl_error <= 1'b0;
    end else begin
      cnt_q     <= cnt_nxt;
      now_q     <= now_q + AGE_W'(1);
      rsp_valid <= req_valid;
      rsp_code  <= req_valid ? verdict : ST_ISSUED;
      if (cpl_valid && !rem_any) cpl_error <= 1'b1;
    end
  end

  lart_watchdog #(.LIM_W(AGE_W - 1)) u_wd (
    .clk(clk), .rst_n(rst_n), .limit(dl_limit), .arm(ins_any),
    .busy_now(cnt_q != '0), .busy_next(cnt_nxt != '0),
    .aged(rd_aged || wr_aged), .flag(deadlock));

  // alias event counters
  logic [CNT_W-1:0] ev_val [EV_NUM];
  for (genvar e = 0; e < EV_NUM; e++) begin : g_ev
    lart_satcnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(ev_inc[e]), .val(ev_val[e]));
  end
  assign ev_st_ld = ev_val[EV_ST_LD];
  assign ev_st_st = ev_val[EV_ST_ST];
  assign ev_ld_ld = ev_val[EV_LD_LD];
  assign ev_ld_st = ev_val[EV_LD_ST];

  // R6: running count agrees with table occupancy
  a_r6_count_is_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == (CNT_OW'(rd_occ) + CNT_OW'(wr_occ)));

  // R8: an issued verdict goes with one more entry (less any completion)
  a_r8_issue_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_code == ST_ISSUED)) |->
      ((cnt_q + CNT_OW'($past(rem_any))) == ($past(cnt_q) + CNT_OW'(1))));

endmodule

// File: tb/test_lart_tracker.sv
module test_lart_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32, LINE_BYTES = 64, ENTRIES = 4, AGE_W = 12, CNT_W = 3;
  localparam int OFF = 6;
  localparam int CNT_OW = $clog2(2 * ENTRIES + 1);
  localparam int CMAX = (1 << CNT_W) - 1;
  localparam int KLD = 0, KIF = 1, KST = 2, KLR = 7, KLW = 8, KFL = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, cpl_valid = 0, cpl_is_write = 0;
  logic [ADDR_W-1:0] req_addr = '0, cpl_addr = '0;
  logic [3:0] req_kind = '0;
  logic [AGE_W-2:0] lim = 11'd1000;
  logic rsp_valid, deadlock, cpl_error;
  logic [1:0] rsp_code;
  logic [CNT_OW-1:0] out_count;
  logic [CNT_W-1:0] ev_st_ld, ev_st_st, ev_ld_ld, ev_ld_st;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lart_tracker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .ENTRIES(ENTRIES),
                 .AGE_W(AGE_W), .CNT_W(CNT_W)) i_lart_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .cpl_valid(cpl_valid), .cpl_is_write(cpl_is_write), .cpl_addr(cpl_addr),
    .dl_limit(lim), .out_count(out_count), .deadlock(deadlock),
    .cpl_error(cpl_error), .ev_st_ld(ev_st_ld), .ev_st_st(ev_st_st),
    .ev_ld_ld(ev_ld_ld), .ev_ld_st(ev_ld_st));

  int n_vec = 0, n_fail = 0;
  string cur_tag = "R13";
  bit cmp_on = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int rq_line[$], rq_iss[$];
  int wq_line[$], wq_iss[$], wq_kind[$];
  bit m_lock_v, m_wd_on, m_dl, m_err, m_rsp_v;
  int m_lock_line, m_wd_left, m_now, m_rsp_code, m_count;
  int m_ev[4];

  task automatic model_reset();
    rq_line.delete(); rq_iss.delete();
    wq_line.delete(); wq_iss.delete(); wq_kind.delete();
    m_lock_v = 0; m_wd_on = 0; m_dl = 0; m_err = 0; m_rsp_v = 0;
    m_lock_line = 0; m_wd_left = 0; m_now = 0; m_rsp_code = 0; m_count = 0;
    for (int i = 0; i < 4; i++) m_ev[i] = 0;
  endtask

  task automatic bump(input int e);
    if (m_ev[e] < CMAX) m_ev[e]++;
  endtask

  task automatic model_step();
    bit scan, isrd, in_rd, in_wr, ins_rd, ins_wr;
    int line, code, l, k, idx, li;
    li = int'(lim);
    scan = m_wd_on && (m_wd_left == 1);
    if (scan) begin
      foreach (rq_iss[i]) if (m_now - rq_iss[i] >= li) m_dl = 1;
      foreach (wq_iss[i]) if (m_now - wq_iss[i] >= li) m_dl = 1;
    end
    code = 0; ins_rd = 0; ins_wr = 0; line = 0;
    if (req_valid) begin
      line = int'(req_addr >> OFF);
      isrd = (req_kind == KLD) || (req_kind == KIF);
      in_rd = 0; in_wr = 0;
      foreach (rq_line[i]) if (rq_line[i] == line) in_rd = 1;
      foreach (wq_line[i]) if (wq_line[i] == line) in_wr = 1;
      if (m_lock_v && m_lock_line == line && req_kind != KLW) code = 1;
      else if (isrd) begin
        if (in_wr) begin code = 1; bump(3); end
        else if (in_rd) begin code = 1; bump(2); end
        else if (rq_line.size() == ENTRIES) code = 2;
        else ins_rd = 1;
      end else begin
        if (in_rd) begin code = 1; bump(0); end
        else if (in_wr) begin code = 1; bump(1); end
        else if (wq_line.size() == ENTRIES) code = 2;
        else ins_wr = 1;
      end
    end
    if (cpl_valid) begin
      l = int'(cpl_addr >> OFF);
      idx = -1;
      if (cpl_is_write) begin
        foreach (wq_line[i]) if (wq_line[i] == l) idx = i;
        if (idx < 0) m_err = 1;
        else begin
          k = wq_kind[idx];
          wq_line.delete(idx); wq_iss.delete(idx); wq_kind.delete(idx);
          if (k == KLR) begin m_lock_v = 1; m_lock_line = l; end
          else if (k == KLW && m_lock_v && m_lock_line == l) m_lock_v = 0;
        end
      end else begin
        foreach (rq_line[i]) if (rq_line[i] == l) idx = i;
        if (idx < 0) m_err = 1;
        else begin rq_line.delete(idx); rq_iss.delete(idx); end
      end
    end
    if (ins_rd) begin rq_line.push_back(line); rq_iss.push_back(m_now); end
    if (ins_wr) begin
      wq_line.push_back(line); wq_iss.push_back(m_now); wq_kind.push_back(int'(req_kind));
    end
    m_count = rq_line.size() + wq_line.size();
    if (scan) begin m_wd_on = (m_count != 0); m_wd_left = li; end
    else if (m_wd_on) m_wd_left--;
    else if (ins_rd || ins_wr) begin m_wd_on = 1; m_wd_left = li; end
    m_rsp_v = req_valid;
    m_rsp_code = req_valid ? code : 0;
    m_now++;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(cur_tag, "rsp_valid", int'(rsp_valid), int'(m_rsp_v));
      if (m_rsp_v) chk(cur_tag, "rsp_code", int'(rsp_code), m_rsp_code);
      chk(cur_tag, "out_count", int'(out_count), m_count);
      chk(cur_tag, "deadlock", int'(deadlock), int'(m_dl));
      chk(cur_tag, "cpl_error", int'(cpl_error), int'(m_err));
      chk(cur_tag, "ev_st_ld", int'(ev_st_ld), m_ev[0]);
      chk(cur_tag, "ev_st_st", int'(ev_st_st), m_ev[1]);
      chk(cur_tag, "ev_ld_ld", int'(ev_ld_ld), m_ev[2]);
      chk(cur_tag, "ev_ld_st", int'(ev_ld_st), m_ev[3]);
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input bit rv, input int rk, input logic [31:0] ra,
                       input bit cv, input bit cw, input logic [31:0] ca);
    req_valid = rv; req_kind = 4'(rk); req_addr = ra;
    cpl_valid = cv; cpl_is_write = cw; cpl_addr = ca;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; cpl_valid = 0;
  endtask

  task automatic op(input int rk, input logic [31:0] ra, input int exp, input string tag);
    drive(1, rk, ra, 0, 0, 0);
    chk(tag, "verdict", int'(rsp_code), exp);
  endtask

  task automatic cpl(input bit wr, input logic [31:0] ca);
    drive(0, 0, 0, 1, wr, ca);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    int sv0, sv1, sv2, sv3;
    @(negedge clk);
    @(negedge clk);
    // R13: reset state
    chk("R13", "rsp_valid", int'(rsp_valid), 0);
    chk("R13", "out_count", int'(out_count), 0);
    chk("R13", "flags", int'({deadlock, cpl_error}), 0);
    chk("R13", "counters", int'({ev_st_ld, ev_st_st, ev_ld_ld, ev_ld_st}), 0);
    rst_n = 1;
    idle(1);
    cmp_on = 1;

    cur_tag = "R1";
    op(KLD, 32'h1000, 0, "R1");
    op(KLD, 32'h103C, 1, "R1");
    op(KLD, 32'h1040, 0, "R1");

    cur_tag = "R2";
    op(KST, 32'h1008, 1, "R2");
    chk("R2", "ev_st_ld", int'(ev_st_ld), 1);
    op(KST, 32'h3000, 0, "R2");
    op(KFL, 32'h3010, 1, "R2");
    chk("R2", "ev_st_st", int'(ev_st_st), 1);

    cur_tag = "R3";
    op(KLD, 32'h3020, 1, "R3");
    chk("R3", "ev_ld_st", int'(ev_ld_st), 1);
    op(KIF, 32'h1000, 1, "R3");
    chk("R3", "ev_ld_ld", int'(ev_ld_ld), 2);

    cur_tag = "R6";
    chk("R6", "out_count", int'(out_count), 3);
    cpl(0, 32'h1000);
    chk("R6", "out_count", int'(out_count), 2);
    cpl(0, 32'h1040);
    cpl(1, 32'h3000);
    chk("R6", "out_count", int'(out_count), 0);

    cur_tag = "R9";
    chk("R9", "cpl_error", int'(cpl_error), 0);
    cpl(1, 32'h1000);
    chk("R9", "cpl_error", int'(cpl_error), 1);

    cur_tag = "R7";
    op(KLD, 32'h4000, 0, "R7");
    op(KLD, 32'h4040, 0, "R7");
    op(KLD, 32'h4080, 0, "R7");
    op(KLD, 32'h40C0, 0, "R7");
    op(KST, 32'h5000, 0, "R7");
    op(KLD, 32'h5000, 1, "R7");
    op(KLD, 32'h6000, 2, "R7");
    op(KST, 32'h6000, 0, "R7");
    cpl(0, 32'h4000); cpl(0, 32'h4040); cpl(0, 32'h4080); cpl(0, 32'h40C0);
    cpl(1, 32'h5000); cpl(1, 32'h6000);
    chk("R7", "out_count", int'(out_count), 0);

    cur_tag = "R8";
    op(KLD, 32'h8000, 0, "R8");
    drive(1, KLD, 32'h8000, 1, 0, 32'h8000);
    chk("R8", "same-cycle verdict", int'(rsp_code), 1);
    chk("R8", "rsp_valid", int'(rsp_valid), 1);
    op(KLD, 32'h8000, 0, "R8");
    cpl(0, 32'h8000);

    cur_tag = "R4";
    op(KLR, 32'h7000, 0, "R4");
    cpl(1, 32'h7000);
    sv0 = int'(ev_st_ld); sv1 = int'(ev_st_st); sv2 = int'(ev_ld_ld); sv3 = int'(ev_ld_st);
    op(KLD, 32'h7000, 1, "R4");
    op(KST, 32'h7010, 1, "R4");
    chk("R4", "counters untouched", int'(ev_st_ld) + int'(ev_st_st) + int'(ev_ld_ld)
        + int'(ev_ld_st), sv0 + sv1 + sv2 + sv3);
    op(KST, 32'h7040, 0, "R4");
    cur_tag = "R5";
    op(KLW, 32'h7000, 0, "R5");
    cpl(1, 32'h7000);
    op(KLD, 32'h7000, 0, "R5");
    cpl(0, 32'h7000);
    cpl(1, 32'h7040);

    cur_tag = "R12";
    op(KST, 32'h9000, 0, "R12");
    for (int i = 0; i < 10; i++) op(KST, 32'h9000, 1, "R12");
    chk("R12", "ev_st_st saturated", int'(ev_st_st), CMAX);
    cpl(1, 32'h9000);

    idle(1100);
    cur_tag = "R10";
    lim = 11'd20;
    chk("R10", "deadlock", int'(deadlock), 0);
    op(KLD, 32'hA000, 0, "R10");
    idle(9);
    op(KLD, 32'hB000, 0, "R10");
    idle(4);
    cpl(0, 32'hA000);
    idle(15);
    chk("R10", "deadlock after first scan", int'(deadlock), 0);
    idle(15);
    chk("R10", "deadlock after second scan", int'(deadlock), 1);
    cur_tag = "R11";
    cpl(0, 32'hB000);
    idle(50);
    chk("R11", "deadlock sticky", int'(deadlock), 1);
    chk("R11", "cpl_error sticky", int'(cpl_error), 1);

    cur_tag = "R8";
    lim = 11'd2000;
    for (int i = 0; i < 3000; i++) begin
      bit rv, cv, cw;
      int rk;
      logic [31:0] ra, ca;
      rv = ($urandom % 10) < 7;
      rk = $urandom % 10;
      ra = 32'h10000 + (($urandom % 8) << OFF) + ($urandom % 64);
      cv = ($urandom % 10) < 4;
      cw = $urandom % 2;
      ca = 32'h10000 + (($urandom % 8) << OFF);
      drive(rv, rk, ra, cv, cw, ca);
    end
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule